// File: doc/BRIEF.md
# Directory-Coherent Cache Controller (Cache Side)

This block is the per-node cache controller of a directory-based coherence scheme. It owns a small direct-mapped cache whose lines each hold a one-word block, a tag, and one of three coherence states: Invalid, Shared or Exclusive. There is no shared bus to watch. Every coherence action travels as an explicit point-to-point message between this node and the home directory of the block.

On the processor side, a read or write that cannot be satisfied locally becomes a read-miss or write-miss message to the home node. The processor is held until the data reply has been installed. Writing back a dirty (Exclusive) victim always comes before the miss that displaces it.

On the network side, the controller accepts invalidate, fetch and fetch-and-invalidate messages from the home node and answers with write-backs. These messages are serviced even while the node's own miss is outstanding, so the home node is never stuck behind this node's request.

Top module: `dirCacheCtrl`

## Requirements
- R1: After reset every line is Invalid, the processor request port is ready, no outgoing message is valid and no processor response is given.
- R2: A processor read on an Invalid or tag-mismatched line sends one message of type 1 (read miss) carrying NODE_ID, the request address and zero data. When a type 7 (data reply) message arrives, the reply word is returned to the processor and the line becomes Shared.
- R3: A processor write to a line that is not Exclusive for that address sends a type 2 (write miss) message. When the data reply arrives, the written word is stored and returned on the response, and the line becomes Exclusive.
- R4: A read that hits a Shared or Exclusive line, and a write that hits an Exclusive line, complete with no outgoing message. A write hit updates the stored word.
- R5: A miss whose direct-mapped victim (index = address bits [2:0]) is Exclusive with a different tag first sends a type 3 (write-back) message with the victim's address and data, then the miss message. A Shared victim is dropped silently.
- R6: An incoming type 4 (invalidate) message turns a matching Shared line Invalid. It has no effect on an Exclusive line or on a line holding another tag.
- R7: An incoming type 5 (fetch) message for a matching Exclusive line sends a type 3 write-back with the line's address and data, and the line becomes Shared.
- R8: An incoming type 6 (fetch-and-invalidate) message for a matching Exclusive line sends a type 3 write-back, and the line becomes Invalid.
- R9: Once a request is accepted, the processor request port stays not ready until the single response for that request has been given.
- R10: Coherence messages that arrive while a miss is waiting for its data are serviced, including any write-back they require, before the data reply is consumed.
- R11: An outgoing message keeps its type, address and data unchanged while it is valid and not yet accepted.
- R12: A fetch or fetch-and-invalidate for a line that is not Exclusive for that address is consumed with no outgoing message and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReqValid | input | 1 | Processor request valid |
| cpuReqReady | output | 1 | Controller can accept a request |
| cpuReqWrite | input | 1 | 1 = write, 0 = read |
| cpuReqAddr | input | ADDR_W | Block address |
| cpuReqWData | input | DATA_W | Write word |
| cpuRespValid | output | 1 | One-cycle completion pulse |
| cpuRespRData | output | DATA_W | Word read, or word written |
| outValid | output | 1 | Outgoing message valid |
| outReady | input | 1 | Network accepts the outgoing message |
| outType | output | 3 | Outgoing type: 1 read miss, 2 write miss, 3 write-back |
| outNode | output | NODE_W | Sending node number |
| outAddr | output | ADDR_W | Block address of the message |
| outData | output | DATA_W | Write-back data, zero for misses |
| inValid | input | 1 | Incoming message valid |
| inReady | output | 1 | Incoming message consumed |
| inType | input | 3 | Incoming type: 4 invalidate, 5 fetch, 6 fetch-and-invalidate, 7 data reply |
| inAddr | input | ADDR_W | Block address of the incoming message |
| inData | input | DATA_W | Reply data |

## Verification
The bench targets dirty-victim eviction, where a missing or reordered write-back would lose the only current copy. It also targets write misses to Shared lines; a design that treated these as hits would skip the directory's exclusive grant. A fetch is injected while the node's own read miss is pending: a design that consumed the reply first, or stalled the fetch behind it, would respond before the write-back or hang. Invalidates and fetches aimed at lines in the wrong state or with another tag check that they are dropped without disturbing the line. Random back-pressure on the outgoing port checks that held messages do not change.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } lineSt_e;

  typedef enum logic [2:0] {
    MSG_RDMISS   = 3'd1,
    MSG_WRMISS   = 3'd2,
    MSG_WBACK    = 3'd3,
    MSG_INVAL    = 3'd4,
    MSG_FETCH    = 3'd5,
    MSG_FETCHINV = 3'd6,
    MSG_DATA     = 3'd7
  } msg_e;

  typedef enum logic [1:0] {
    SEL_VICTIM  = 2'd0,
    SEL_MISS    = 2'd1,
    SEL_FETCHWB = 2'd2
  } outSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    reqLatch;
    logic    writeHit;
    logic    markMiss;
    logic    fill;
    logic    invLine;
    logic    demote;
    outSel_e outSel;
  } ctlStrb_t;

endpackage

// File: rtl/dccDatapath.sv
module dccDatapath
  import dcc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          ctl,
  input  logic              cpuReqWrite,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  input  logic [DATA_W-1:0] cpuReqWData,
  input  logic [2:0]        inType,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  output logic              reqWrite,
  output logic              reqHit,
  output logic              reqExcl,
  output logic              victimDirty,
  output lineSt_e           snpState,
  output logic [2:0]        outType,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData,
  output logic [DATA_W-1:0] cpuRespRData
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  lineSt_e           stateArr [LINES];
  logic [TAG_W-1:0]  tagArr   [LINES];
  logic [DATA_W-1:0] dataArr  [LINES];

  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWData;

  logic [IDX_W-1:0]  reqIdx, snpIdx;
  logic [TAG_W-1:0]  reqTag, snpTag;
  lineSt_e           curSt;
  logic [TAG_W-1:0]  curTag;
  logic              tagEq;

  assign reqIdx = reqAddr[IDX_W-1:0];
  assign reqTag = reqAddr[ADDR_W-1:IDX_W];
  assign snpIdx = inAddr[IDX_W-1:0];
  assign snpTag = inAddr[ADDR_W-1:IDX_W];

  assign curSt  = stateArr[reqIdx];
  assign curTag = tagArr[reqIdx];
  assign tagEq  = (curTag == reqTag);

  assign reqHit      = (curSt != LN_INV) && tagEq;
  assign reqExcl     = (curSt == LN_EXC) && tagEq;
  assign victimDirty = (curSt == LN_EXC) && !tagEq;
  assign snpState    = (tagArr[snpIdx] == snpTag) ? stateArr[snpIdx] : LN_INV;

  assign cpuRespRData = dataArr[reqIdx];

  // request register and line states
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqWData <= '0;
      reqWrite <= 1'b0;
      for (int i = 0; i < LINES; i++) stateArr[i] <= LN_INV;
    end else begin
      if (ctl.reqLatch) begin
        reqAddr  <= cpuReqAddr;
        reqWData <= cpuReqWData;
        reqWrite <= cpuReqWrite;
      end
      if (ctl.markMiss) stateArr[reqIdx] <= LN_INV;
      if (ctl.fill)     stateArr[reqIdx] <= reqWrite ? LN_EXC : LN_SHR;
      if (ctl.invLine && snpState == LN_SHR) stateArr[snpIdx] <= LN_INV;
      if (ctl.demote)
        stateArr[snpIdx] <= (inType == MSG_FETCH) ? LN_SHR : LN_INV;
    end
  end

  // tags and data need no reset: state gates them
  always_ff @(posedge clk) begin
    if (ctl.markMiss) tagArr[reqIdx] <= reqTag;
    if (ctl.writeHit) dataArr[reqIdx] <= reqWData;
    if (ctl.fill)     dataArr[reqIdx] <= reqWrite ? reqWData : inData;
  end

  always_comb begin
    outType = MSG_WBACK;
    outAddr = reqAddr;
    outData = '0;
    case (ctl.outSel)
      SEL_VICTIM: begin
        outType = MSG_WBACK;
        outAddr = {curTag, reqIdx};
        outData = dataArr[reqIdx];
      end
      SEL_MISS: begin
        outType = reqWrite ? MSG_WRMISS : MSG_RDMISS;
        outAddr = reqAddr;
        outData = '0;
      end
      SEL_FETCHWB: begin
        outType = MSG_WBACK;
        outAddr = inAddr;
        outData = dataArr[snpIdx];
      end
      default: ;
    endcase
  end

  // ---- assertions ----
  logic [IDX_W-1:0] snpIdxQ;
  always_ff @(posedge clk) snpIdxQ <= snpIdx;

  AST_FILL_SHARED: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fill && !reqWrite |=> stateArr[reqIdx] == LN_SHR); // R2
  AST_FILL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fill && reqWrite |=> stateArr[reqIdx] == LN_EXC); // R3
  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.invLine && snpState == LN_SHR |=> stateArr[snpIdxQ] == LN_INV); // R6
  AST_DEMOTE_DROPS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    ctl.demote |=> stateArr[snpIdxQ] != LN_EXC); // R7

endmodule

// File: rtl/dccControl.sv
module dccControl
  import dcc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReqValid,
  input  logic       reqWrite,
  input  logic       reqHit,
  input  logic       reqExcl,
  input  logic       victimDirty,
  input  lineSt_e    snpState,
  input  logic       inValid,
  input  logic [2:0] inType,
  input  logic       outReady,
  output logic       cpuReqReady,
  output logic       cpuRespValid,
  output logic       inReady,
  output logic       outValid,
  output ctlStrb_t   ctl
);

  typedef enum logic [2:0] {
    CS_IDLE, CS_LOOKUP, CS_SENDVWB, CS_SENDMISS, CS_WAIT, CS_FETCHWB, CS_RESP
  } ctlSt_e;

  ctlSt_e st, nextSt;
  logic   retWait, nextRet;
  logic   isCoh, cohNow;

  assign isCoh  = (inType == MSG_INVAL) || (inType == MSG_FETCH) || (inType == MSG_FETCHINV);
  assign cohNow = inValid && isCoh && (st == CS_IDLE || st == CS_WAIT);

  always_comb begin
    nextSt       = st;
    nextRet      = retWait;
    cpuReqReady  = 1'b0;
    cpuRespValid = 1'b0;
    inReady      = 1'b0;
    outValid     = 1'b0;
    ctl          = '0;
    ctl.outSel   = SEL_MISS;

    // coherence traffic first, in both idle and waiting states
    if (cohNow) begin
      if (inType == MSG_INVAL) begin
        inReady     = 1'b1;
        ctl.invLine = 1'b1;
      end else if (snpState == LN_EXC) begin
        nextSt  = CS_FETCHWB;
        nextRet = (st == CS_WAIT);
      end else begin
        inReady = 1'b1;
      end
    end

    case (st)
      CS_IDLE: if (!cohNow) begin
        if (inValid) inReady = 1'b1;
        cpuReqReady = 1'b1;
        if (cpuReqValid) begin
          ctl.reqLatch = 1'b1;
          nextSt       = CS_LOOKUP;
        end
      end
      CS_LOOKUP: begin
        if (!reqWrite && reqHit) nextSt = CS_RESP;
        else if (reqWrite && reqExcl) begin
          ctl.writeHit = 1'b1;
          nextSt       = CS_RESP;
        end else if (victimDirty) nextSt = CS_SENDVWB;
        else nextSt = CS_SENDMISS;
      end
      CS_SENDVWB: begin
        outValid   = 1'b1;
        ctl.outSel = SEL_VICTIM;
        if (outReady) nextSt = CS_SENDMISS;
      end
      CS_SENDMISS: begin
        outValid   = 1'b1;
        ctl.outSel = SEL_MISS;
        if (outReady) begin
          ctl.markMiss = 1'b1;
          nextSt       = CS_WAIT;
        end
      end
      CS_WAIT: if (!cohNow && inValid) begin
        inReady = 1'b1;
        if (inType == MSG_DATA) begin
          ctl.fill = 1'b1;
          nextSt   = CS_RESP;
        end
      end
      CS_FETCHWB: begin
        outValid   = 1'b1;
        ctl.outSel = SEL_FETCHWB;
        if (outReady) begin
          inReady    = 1'b1;
          ctl.demote = 1'b1;
          nextSt     = retWait ? CS_WAIT : CS_IDLE;
        end
      end
      CS_RESP: begin
        cpuRespValid = 1'b1;
        nextSt       = CS_IDLE;
      end
      default: nextSt = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= CS_IDLE;
      retWait <= 1'b0;
    end else begin
      st      <= nextSt;
      retWait <= nextRet;
    end
  end

  // ---- assertions ----
  AST_MISS_AFTER_VICTIM: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && ctl.outSel == SEL_VICTIM |=> outValid && ctl.outSel == SEL_MISS); // R5
  AST_COH_BEFORE_FILL: assert property (@(posedge clk) disable iff (!rstN)
    inValid && isCoh |-> !ctl.fill); // R10

endmodule

// File: rtl/dirCacheCtrl.sv
module dirCacheCtrl
  import dcc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int LINES   = 8,
  parameter int NODE_W  = 2,
  parameter int NODE_ID = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReqValid,
  output logic              cpuReqReady,
  input  logic              cpuReqWrite,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  input  logic [DATA_W-1:0] cpuReqWData,
  output logic              cpuRespValid,
  output logic [DATA_W-1:0] cpuRespRData,
  output logic              outValid,
  input  logic              outReady,
  output logic [2:0]        outType,
  output logic [NODE_W-1:0] outNode,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData,
  input  logic              inValid,
  output logic              inReady,
  input  logic [2:0]        inType,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData
);

  ctlStrb_t ctl;
  logic     reqWrite, reqHit, reqExcl, victimDirty;
  lineSt_e  snpState;

  assign outNode = NODE_W'(NODE_ID);

  dccControl i_ctl (
    .clk(clk), .rstN(rstN), .cpuReqValid(cpuReqValid),
    .reqWrite(reqWrite), .reqHit(reqHit), .reqExcl(reqExcl),
    .victimDirty(victimDirty), .snpState(snpState),
    .inValid(inValid), .inType(inType), .outReady(outReady),
    .cpuReqReady(cpuReqReady), .cpuRespValid(cpuRespValid),
    .inReady(inReady), .outValid(outValid), .ctl(ctl)
  );

  dccDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .cpuReqWrite(cpuReqWrite), .cpuReqAddr(cpuReqAddr), .cpuReqWData(cpuReqWData),
    .inType(inType), .inAddr(inAddr), .inData(inData),
    .reqWrite(reqWrite), .reqHit(reqHit), .reqExcl(reqExcl),
    .victimDirty(victimDirty), .snpState(snpState),
    .outType(outType), .outAddr(outAddr), .outData(outData),
    .cpuRespRData(cpuRespRData)
  );

  // ---- assertions ----
  logic pending;
  always_ff @(posedge clk) begin
    if (!rstN) pending <= 1'b0;
    else if (cpuReqValid && cpuReqReady) pending <= 1'b1;
    else if (cpuRespValid) pending <= 1'b0;
  end

  AST_STALL_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> !cpuReqReady); // R9
  AST_RESP_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    cpuRespValid |-> pending); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outType) && $stable(outAddr) && $stable(outData)); // R11

endmodule

// File: tb/test_dirCacheCtrl.sv
module test_dirCacheCtrl;
  import dcc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NODE_ID    = 1;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [2:0]  t;
    logic [7:0]  a;
    logic [31:0] d;
  } msg_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReqValid = 1'b0, cpuReqWrite = 1'b0;
  logic [7:0]  cpuReqAddr = '0;
  logic [31:0] cpuReqWData = '0;
  logic        cpuReqReady, cpuRespValid;
  logic [31:0] cpuRespRData;
  logic        outValid, outReady = 1'b0;
  logic [2:0]  outType;
  logic [1:0]  outNode;
  logic [7:0]  outAddr;
  logic [31:0] outData;
  logic        inValid = 1'b0, inReady;
  logic [2:0]  inType = '0;
  logic [7:0]  inAddr = '0;
  logic [31:0] inData = '0;

  dirCacheCtrl i_dirCacheCtrl (
    .clk(clk), .rstN(rstN),
    .cpuReqValid(cpuReqValid), .cpuReqReady(cpuReqReady), .cpuReqWrite(cpuReqWrite),
    .cpuReqAddr(cpuReqAddr), .cpuReqWData(cpuReqWData),
    .cpuRespValid(cpuRespValid), .cpuRespRData(cpuRespRData),
    .outValid(outValid), .outReady(outReady), .outType(outType), .outNode(outNode),
    .outAddr(outAddr), .outData(outData),
    .inValid(inValid), .inReady(inReady), .inType(inType), .inAddr(inAddr), .inData(inData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFail = 0;
  string curReq = "R1";
  msg_t expQ[$];
  logic [31:0] respQ[$];
  int missSent = 0, missBase = 0;
  bit busy = 0, done = 0;

  // reference model: one entry per direct-mapped line
  int          mSt  [8];
  logic [4:0]  mTag [8];
  logic [31:0] mData[8];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // back-pressure on outgoing port
  logic [7:0] lfsr = 8'h5a;
  initial forever begin
    @(posedge clk);
    lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    outReady <= lfsr[0] | lfsr[2];
  end

  // per-cycle comparison against the model's expectations
  bit holdPend = 0;
  msg_t held;
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (busy) chk(cpuReqReady == 1'b0, "R9", "ready while busy", 64'(cpuReqReady), 0);
      if (holdPend)
        chk(outValid && {outType, outAddr, outData} == held, "R11", "held message changed",
            64'({outType, outAddr, outData}), 64'(held));
      holdPend = outValid && !outReady;
      held     = {outType, outAddr, outData};
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          chk(0, curReq, "unexpected message", 64'({outType, outAddr, outData}), 0);
        end else begin
          msg_t e;
          e = expQ.pop_front();
          chk({outType, outAddr, outData} == e && outNode == 2'(NODE_ID), curReq,
              "outgoing message", 64'({outType, outAddr, outData}), 64'(e));
        end
        if (outType == MSG_RDMISS || outType == MSG_WRMISS) missSent++;
      end
      if (cpuRespValid) begin
        chk(expQ.size() == 0, "R10", "messages outstanding at response", 64'(expQ.size()), 0);
        if (respQ.size() == 0) chk(0, "R9", "response with none expected", 64'(cpuRespRData), 0);
        else begin
          logic [31:0] r;
          r = respQ.pop_front();
          chk(cpuRespRData == r, curReq, "response data", 64'(cpuRespRData), 64'(r));
        end
        busy = 0;
      end
    end
  end

  task automatic sendIn(input logic [2:0] t, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    inValid = 1'b1; inType = t; inAddr = a; inData = d;
    #1;
    while (!inReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic cpuStart(input bit w, input logic [7:0] a, input logic [31:0] wd,
                          input logic [31:0] reply, output bit miss);
    int idx;
    bit hit;
    idx = int'(a[2:0]);
    hit = mSt[idx] != 0 && mTag[idx] == a[7:3] && (!w || mSt[idx] == 2);
    miss = !hit;
    if (miss) begin
      if (mSt[idx] == 2 && mTag[idx] != a[7:3])
        expQ.push_back({MSG_WBACK, {mTag[idx], a[2:0]}, mData[idx]});
      expQ.push_back({w ? MSG_WRMISS : MSG_RDMISS, a, 32'h0});
    end
    if (w) begin mData[idx] = wd; mSt[idx] = 2; end
    else if (miss) begin mData[idx] = reply; mSt[idx] = 1; end
    mTag[idx] = a[7:3];
    respQ.push_back(mData[idx]);
    missBase = missSent;
    @(negedge clk); #1;
    cpuReqValid = 1'b1; cpuReqWrite = w; cpuReqAddr = a; cpuReqWData = wd;
    #1;
    while (!cpuReqReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cpuReqValid = 1'b0;
    busy = 1;
  endtask

  task automatic waitMiss();
    while (missSent == missBase) @(negedge clk);
  endtask

  task automatic waitResp();
    while (busy) @(negedge clk);
  endtask

  task automatic access(input bit w, input logic [7:0] a, input logic [31:0] wd,
                        input logic [31:0] reply);
    bit miss;
    cpuStart(w, a, wd, reply, miss);
    if (miss) begin
      waitMiss();
      sendIn(MSG_DATA, a, reply);
    end
    waitResp();
  endtask

  task automatic coh(input logic [2:0] t, input logic [7:0] a);
    int idx;
    idx = int'(a[2:0]);
    if (mTag[idx] == a[7:3]) begin
      if (t == MSG_INVAL && mSt[idx] == 1) mSt[idx] = 0;
      if ((t == MSG_FETCH || t == MSG_FETCHINV) && mSt[idx] == 2) begin
        expQ.push_back({MSG_WBACK, a, mData[idx]});
        mSt[idx] = (t == MSG_FETCH) ? 1 : 0;
      end
    end
    sendIn(t, a, 32'h0);
    repeat (6) @(negedge clk);
  endtask

  task automatic drained(input string req);
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0 && respQ.size() == 0, req, "queues drained",
        64'(expQ.size()), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R9 watchdog expired act=%0d exp=0", WATCHDOG);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mSt[i] = 0; mTag[i] = '0; mData[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(cpuReqReady == 1'b1, "R1", "ready after reset", 64'(cpuReqReady), 1);
    chk(outValid == 1'b0, "R1", "no message after reset", 64'(outValid), 0);
    chk(cpuRespValid == 1'b0, "R1", "no response after reset", 64'(cpuRespValid), 0);

    curReq = "R2"; access(0, 8'h11, 0, 32'hAAAA0001); drained("R2");
    curReq = "R4"; access(0, 8'h11, 0, 0); drained("R4");
    curReq = "R3"; access(1, 8'h11, 32'h0000BEEF, 32'h12345678); drained("R3");
    curReq = "R4"; access(1, 8'h11, 32'h0000CAFE, 0); access(0, 8'h11, 0, 0); drained("R4");
    curReq = "R5"; access(0, 8'h19, 0, 32'h19191919); drained("R5");
    curReq = "R5"; access(0, 8'h21, 0, 32'h21212121); drained("R5");
    curReq = "R6"; coh(MSG_INVAL, 8'h29); access(0, 8'h21, 0, 0); drained("R6");
    curReq = "R6"; coh(MSG_INVAL, 8'h21); access(0, 8'h21, 0, 32'h21000021); drained("R6");
    curReq = "R3"; access(1, 8'h32, 32'h32323232, 32'h0); drained("R3");
    curReq = "R6"; coh(MSG_INVAL, 8'h32); access(0, 8'h32, 0, 0); drained("R6");
    curReq = "R7"; coh(MSG_FETCH, 8'h32); access(0, 8'h32, 0, 0); drained("R7");
    curReq = "R7"; access(1, 8'h32, 32'h77777777, 32'h0); drained("R7");
    curReq = "R8"; coh(MSG_FETCHINV, 8'h32); access(0, 8'h32, 0, 32'h88888888); drained("R8");
    curReq = "R12"; coh(MSG_FETCH, 8'h45); coh(MSG_FETCHINV, 8'h32); coh(MSG_FETCH, 8'h3A);
    access(0, 8'h32, 0, 0); drained("R12");
    // R10: fetch while own miss waits for data
    curReq = "R10"; access(1, 8'h53, 32'h53535353, 32'h0);
    begin
      bit miss;
      cpuStart(0, 8'h14, 0, 32'h14141414, miss);
      waitMiss();
      coh(MSG_FETCHINV, 8'h53);
      chk(busy == 1, "R10", "response withheld while fetch serviced", 64'(busy), 1);
      sendIn(MSG_DATA, 8'h14, 32'h14141414);
      waitResp();
    end
    drained("R10");
    curReq = "R5"; access(1, 8'h63, 32'h63636363, 32'h0); access(1, 8'h6B, 32'h6B6B6B6B, 32'h0);
    drained("R5");
    curReq = "R2"; access(0, 8'h07, 0, 32'h07070707); access(0, 8'h07, 0, 0); drained("R2");

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule